// File: doc/BRIEF.md
# Downstream Port Status and Control Register

This block holds the status and control state of one downstream port of a high-speed USB host controller. Software sees the state as a single 32-bit word at one offset on a simple synchronous register bus. It reads the live line state, the attach state and the port flags there, and it writes the same word to start or end a bus reset, to suspend the port, or to force the port into high-speed test mode. The outputs are registered drive requests for bus reset, suspend and forced high-speed test, plus a one-cycle port-change interrupt.

The register sits in a power well. Only the power-on reset or the host-controller reset clears it. Bus reset is timed by software: one write of 1 starts it and a later write of 0 ends it. The block does not count the reset length. A bus reset can only be started while the controller is halted (Run/Stop at 0).

Top module: `usb_port_stsctl`

## Requirements
- R1: Either `por_rst` or `hc_rst`, sampled high at a clock edge, clears every field and every output. The word then reads 0 except for the line-state field.
- R2: A read strobe at offset 0x30 returns the word on `reg_rdata` one clock after the strobe. A read of any other address returns 0. Bits [31:17], [15:12], 9, [6:3] and 1 always read 0, and writes to them have no effect.
- R3: Bit 16 (test force) is read/write and drives `drv_hs_test`. Bit 2 (port enabled) is read-only and reads 1 while test force is 1.
- R4: Bits [11:10] show `{line_dp, line_dm}` after a two-flop synchronizer: 00 = SE0, 10 = J, 01 = K, 11 = undefined. A change on the lines appears in a read strobed two clocks later.
- R5: Writing 1 to bit 8 (port reset) while `run_stop` is 0 sets the bit and raises `drv_bus_reset` one clock later. Writing 0 clears both.
- R6: A write with bit 8 at 1 while `run_stop` is 1 leaves bit 8 and `drv_bus_reset` at their old values, so a port not in reset stays out of reset.
- R7: Bit 7 (suspend) is read/write and drives `drv_suspend`. A write that leaves port reset at 1 forces suspend to 0. This also holds when bits 8 and 7 are both written as 1 in the same write.
- R8: Bit 0 (connected) follows `dev_attach` after one register stage. `port_chg_irq` is high for exactly one clock after each rising edge of `dev_attach`, and a held-high attach gives only one pulse.
- R9: A write to an address other than 0x30 changes no field and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| hc_rst | input | 1 | Host-controller reset, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| dev_attach | input | 1 | Device attach indication |
| run_stop | input | 1 | Controller Run/Stop bit |
| drv_bus_reset | output | 1 | Request to drive bus reset |
| drv_suspend | output | 1 | Request to suspend the port |
| drv_hs_test | output | 1 | Request to force high-speed test enable |
| port_chg_irq | output | 1 | Port-change pulse |

## Verification
Two cases can fall in the same cycle. In the first, one write carries both the port-reset bit and the suspend bit. The bench sends such a write with the controller halted and expects reset set and suspend cleared. It sends it again with the controller running and expects reset blocked and suspend accepted. In the second case, an attach edge lands while a suspended port is being read. The bench raises the attach indication while a suspend is active, then checks the one-cycle pulse and the combined word that holds both the connected and suspend bits.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  localparam int WORD_W    = 32;
  localparam int BIT_TEST  = 16;
  localparam int BIT_LS_HI = 11;
  localparam int BIT_LS_LO = 10;
  localparam int BIT_PRST  = 8;
  localparam int BIT_SUSP  = 7;
  localparam int BIT_EN    = 2;
  localparam int BIT_CONN  = 0;

  typedef enum logic [1:0] {
    LS_SE0   = 2'b00,
    LS_K     = 2'b01,
    LS_J     = 2'b10,
    LS_UNDEF = 2'b11
  } line_state_e;

  typedef struct packed {
    logic test_en;
    logic prst;
    logic susp;
    logic conn;
  } port_state_t;

  function automatic line_state_e decode_line(input logic dp, input logic dm);
    case ({dp, dm})
      2'b10:   return LS_J;
      2'b01:   return LS_K;
      2'b00:   return LS_SE0;
      default: return LS_UNDEF;
    endcase
  endfunction
endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync
  import usb_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dp_in,
  input  logic        dm_in,
  output line_state_e state_o
);
  logic [STAGES-1:0] dp_sh;
  logic [STAGES-1:0] dm_sh;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            dp_sh[0] <= 1'b0;
            dm_sh[0] <= 1'b0;
          end else begin
            dp_sh[0] <= dp_in;
            dm_sh[0] <= dm_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            dp_sh[g] <= 1'b0;
            dm_sh[g] <= 1'b0;
          end else begin
            dp_sh[g] <= dp_sh[g-1];
            dm_sh[g] <= dm_sh[g-1];
          end
        end
      end
    end
  endgenerate

  always_comb state_o = decode_line(dp_sh[STAGES-1], dm_sh[STAGES-1]);
endmodule

// File: rtl/usb_attach_det.sv
module usb_attach_det (
  input  logic clk,
  input  logic rst,
  input  logic attach_in,
  output logic conn_o,
  output logic chg_o
);
  logic att_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      att_q  <= 1'b0;
      conn_o <= 1'b0;
      chg_o  <= 1'b0;
    end else begin
      att_q  <= attach_in;
      conn_o <= attach_in;
      chg_o  <= attach_in & ~att_q;
    end
  end
endmodule

// File: rtl/usb_port_ctl.sv
module usb_port_ctl
  import usb_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_hit,
  input  logic        wr_test,
  input  logic        wr_prst,
  input  logic        wr_susp,
  input  logic        run_stop,
  output logic        test_en_o,
  output logic        prst_o,
  output logic        susp_o
);
  logic prst_nxt;

  always_comb begin
    prst_nxt = prst_o;
    if (wr_hit) begin
      if (!wr_prst)
        prst_nxt = 1'b0;
      else if (!run_stop)
        prst_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_en_o <= 1'b0;
      prst_o    <= 1'b0;
      susp_o    <= 1'b0;
    end else if (wr_hit) begin
      test_en_o <= wr_test;
      prst_o    <= prst_nxt;
      susp_o    <= wr_susp & ~prst_nxt;
    end
  end
endmodule

// File: rtl/usb_port_stsctl.sv
module usb_port_stsctl
  import usb_port_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  REG_OFFSET  = 8'h30,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              hc_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              line_dp,
  input  logic              line_dm,
  input  logic              dev_attach,
  input  logic              run_stop,
  output logic              drv_bus_reset,
  output logic              drv_suspend,
  output logic              drv_hs_test,
  output logic              port_chg_irq
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic          rst;
  logic          hit;
  line_state_e   ls;
  port_state_t   st;
  logic [31:0]   word;

  always_comb rst = por_rst | hc_rst;
  always_comb hit = (reg_addr == HIT_ADDR);

  usb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .dp_in   (line_dp),
    .dm_in   (line_dm),
    .state_o (ls)
  );

  usb_attach_det u_att (
    .clk       (clk),
    .rst       (rst),
    .attach_in (dev_attach),
    .conn_o    (st.conn),
    .chg_o     (port_chg_irq)
  );

  usb_port_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_hit    (reg_wr & hit),
    .wr_test   (reg_wdata[BIT_TEST]),
    .wr_prst   (reg_wdata[BIT_PRST]),
    .wr_susp   (reg_wdata[BIT_SUSP]),
    .run_stop  (run_stop),
    .test_en_o (st.test_en),
    .prst_o    (st.prst),
    .susp_o    (st.susp)
  );

  always_comb begin
    word                       = '0;
    word[BIT_TEST]             = st.test_en;
    word[BIT_LS_HI:BIT_LS_LO]  = ls;
    word[BIT_PRST]             = st.prst;
    word[BIT_SUSP]             = st.susp;
    word[BIT_EN]               = st.test_en;
    word[BIT_CONN]             = st.conn;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd && hit)
      reg_rdata <= word;
    else
      reg_rdata <= '0;
  end

  always_comb begin
    drv_bus_reset = st.prst;
    drv_suspend   = st.susp;
    drv_hs_test   = st.test_en;
  end
endmodule

// File: rtl/usb_port_stsctl_chk.sv
module usb_port_stsctl_chk #(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] REG_OFFSET = 8'h30
) (
  input logic              clk,
  input logic              por_rst,
  input logic              hc_rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              dev_attach,
  input logic              run_stop,
  input logic              drv_bus_reset,
  input logic              drv_suspend,
  input logic              drv_hs_test,
  input logic              port_chg_irq
);
  logic rst_any;
  logic wr_here;
  always_comb rst_any = por_rst | hc_rst;
  always_comb wr_here = reg_wr && (reg_addr == ADDR_W'(REG_OFFSET));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst_any |=> (!drv_bus_reset && !drv_suspend && !drv_hs_test && !port_chg_irq));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst_any)
    (reg_rdata[31:17] == 15'd0) && (reg_rdata[15:12] == 4'd0) && !reg_rdata[9]);

  p_prst_set_r5: assert property (@(posedge clk) disable iff (rst_any)
    (wr_here && reg_wdata[8] && !run_stop) |=> drv_bus_reset);

  p_run_blocks_r6: assert property (@(posedge clk) disable iff (rst_any)
    (wr_here && reg_wdata[8] && run_stop && !drv_bus_reset) |=> !drv_bus_reset);

  p_susp_hold_r7: assert property (@(posedge clk) disable iff (rst_any)
    drv_bus_reset |-> !drv_suspend);

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst_any)
    port_chg_irq |=> !port_chg_irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst_any)
    port_chg_irq |-> $past(dev_attach));

  p_no_write_r9: assert property (@(posedge clk) disable iff (rst_any)
    !wr_here |=> ($stable(drv_bus_reset) && $stable(drv_suspend) && $stable(drv_hs_test)));
endmodule

bind usb_port_stsctl usb_port_stsctl_chk #(
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) chk_i (
  .clk           (clk),
  .por_rst       (por_rst),
  .hc_rst        (hc_rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .dev_attach    (dev_attach),
  .run_stop      (run_stop),
  .drv_bus_reset (drv_bus_reset),
  .drv_suspend   (drv_suspend),
  .drv_hs_test   (drv_hs_test),
  .port_chg_irq  (port_chg_irq)
);

// File: tb/usb_port_stsctl_tb_top.sv
module usb_port_stsctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFFS = 8'h30;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1, hc_rst = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        line_dp = 1'b0, line_dm = 1'b0;
  logic        dev_attach = 1'b0, run_stop = 1'b0;
  logic        drv_bus_reset, drv_suspend, drv_hs_test, port_chg_irq;

  int n_run = 0;
  int n_fail = 0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_port_stsctl dut_i (
    .clk           (clk),
    .por_rst       (por_rst),
    .hc_rst        (hc_rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .line_dp       (line_dp),
    .line_dm       (line_dm),
    .dev_attach    (dev_attach),
    .run_stop      (run_stop),
    .drv_bus_reset (drv_bus_reset),
    .drv_suspend   (drv_suspend),
    .drv_hs_test   (drv_hs_test),
    .port_chg_irq  (port_chg_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a strobe seen at a rising edge yields data checked at the next falling edge
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard empty actual=%h expected=none", reg_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back('{exp: exp, tag: tag});
    reg_addr <= a; reg_rd <= 1'b1;
    @(negedge clk);
    reg_rd <= 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr <= a; reg_wdata <= d; reg_wr <= 1'b1;
    @(negedge clk);
    reg_wr <= 1'b0; reg_wdata <= '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    por_rst <= 1'b0;
    idle(1);
    // R1: reset state
    check("R1 outputs after power-on reset",
          {28'd0, drv_bus_reset, drv_suspend, drv_hs_test, port_chg_irq}, 32'd0);
    do_read(OFFS, 32'h0000_0000, "R1 word after reset");

    // R4: line states
    line_dp <= 1'b1; line_dm <= 1'b0; idle(3);
    do_read(OFFS, 32'h0000_0800, "R4 J state");
    line_dp <= 1'b0; line_dm <= 1'b1; idle(3);
    do_read(OFFS, 32'h0000_0400, "R4 K state");
    line_dp <= 1'b1; line_dm <= 1'b1; idle(3);
    do_read(OFFS, 32'h0000_0C00, "R4 undefined state");
    line_dp <= 1'b0; line_dm <= 1'b0; idle(3);
    do_read(OFFS, 32'h0000_0000, "R4 SE0 state");

    // R2, R3, R6, R7: all ones while running
    run_stop <= 1'b1;
    do_write(OFFS, 32'hFFFF_FFFF);
    do_read(OFFS, 32'h0001_0084, "R2 R3 R6 R7 all-ones write while running");
    check("R3 drv_hs_test", {31'd0, drv_hs_test}, 32'd1);
    check("R6 drv_bus_reset blocked", {31'd0, drv_bus_reset}, 32'd0);
    check("R7 drv_suspend set", {31'd0, drv_suspend}, 32'd1);

    // R9 and R2 other address
    do_write(8'h34, 32'h0000_0000);
    do_read(OFFS, 32'h0001_0084, "R9 foreign write ignored");
    check("R9 outputs held", {29'd0, drv_bus_reset, drv_suspend, drv_hs_test}, 32'd3);
    do_read(8'h34, 32'h0000_0000, "R2 foreign read zero");

    // R5, R7: reset and suspend together while halted
    run_stop <= 1'b0;
    do_write(OFFS, 32'h0000_0180);
    do_read(OFFS, 32'h0000_0100, "R5 R7 reset wins over suspend");
    check("R5 drv_bus_reset set", {30'd0, drv_bus_reset, drv_suspend}, 32'd2);
    do_write(OFFS, 32'h0000_0180);
    check("R7 suspend held off during reset", {31'd0, drv_suspend}, 32'd0);

    // R6: running with reset already set leaves it set
    run_stop <= 1'b1;
    do_write(OFFS, 32'h0000_0100);
    check("R6 reset kept while running", {31'd0, drv_bus_reset}, 32'd1);
    // R5: write 0 ends reset, suspend accepted
    do_write(OFFS, 32'h0000_0080);
    do_read(OFFS, 32'h0000_0080, "R5 reset cleared, suspend set");
    check("R5 drv_bus_reset cleared", {31'd0, drv_bus_reset}, 32'd0);

    // R8: attach pulse while suspended
    @(negedge clk); dev_attach <= 1'b1;
    @(negedge clk);
    check("R8 irq pulse high", {31'd0, port_chg_irq}, 32'd1);
    @(negedge clk);
    check("R8 irq single cycle", {31'd0, port_chg_irq}, 32'd0);
    do_read(OFFS, 32'h0000_0081, "R8 connected with suspend");
    idle(3);
    check("R8 no repeat while held", {31'd0, port_chg_irq}, 32'd0);
    dev_attach <= 1'b0; idle(2);
    do_read(OFFS, 32'h0000_0080, "R8 detached");
    dev_attach <= 1'b1;
    @(negedge clk);
    check("R8 second edge pulse", {31'd0, port_chg_irq}, 32'd1);
    dev_attach <= 1'b0; idle(2);

    // R1: host-controller reset clears state
    do_write(OFFS, 32'h0001_0080);
    @(negedge clk); hc_rst <= 1'b1;
    @(negedge clk); hc_rst <= 1'b0;
    check("R1 outputs after controller reset",
          {29'd0, drv_bus_reset, drv_suspend, drv_hs_test}, 32'd0);
    do_read(OFFS, 32'h0000_0000, "R1 word after controller reset");

    idle(4);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule